// File: doc/BRIEF.md
# Drum Sector Search and Track Latch

This block locates a word on a rotating serial drum. A word address is twelve bits wide: a six-bit track number and a six-bit sector number. The address arrives one digit per digit period, least significant digit first. During the instruction search it comes from the program counter's serial stream. During the operand search it comes from the instruction register's serial stream. The `phaseSel` input picks the source.

Within each word period, a timing track announces the sector number of the word that follows. The block compares that announcement with the sector part of the address. A single match flag is preset at the end of every word period and is cleared by any mismatching digit in the sector window. If the flag is still set in the last digit period of a word, the next word under the head is the one wanted, and the block raises `seekDone` for that digit.

During the track window, the track part of the address shifts through a six-stage latch. Outside that window the latch holds its value, so the bulk-memory head selection stays steady for the rest of the word and through the phase that follows. The drum itself is modelled only by the bench.

Top module: `drum_seek_unit`

## Requirements
- R1: After reset, `matchFlag` is 0 and `trackBits` is all zero.
- R2: In a clock cycle with `wordEnd` high, `matchFlag` becomes 1 at the end of that cycle. This holds whatever the other inputs are, including a mismatch in a sector-window digit in the same cycle.
- R3: In a cycle with `searchActive`, `winSector` and `wordEnd` low, `matchFlag` becomes 0 at the end of the cycle if `announce` differs from the selected address digit. If they agree, `matchFlag` is unchanged.
- R4: `seekDone` is high exactly in a `wordEnd` cycle with `searchActive` high while `matchFlag` is 1. After a preset, this happens when all six sector digits of the word agreed with the announcement.
- R5: The selected address digit is `digitCtr` when `phaseSel` is 0 (instruction search) and `digitInstr` when `phaseSel` is 1 (operand search). The other stream has no effect.
- R6: In a cycle with `searchActive` and `winTrack` high, the latch shifts by one stage. The selected digit enters the top stage, `trackBits[5]`, and each stage passes its value one place toward bit 0. After six such cycles fed least significant digit first, `trackBits` equals the track number with its first digit at bit 0.
- R7: In any cycle without both `searchActive` and `winTrack` high, `trackBits` keeps its value.
- R8: With `searchActive` low, the sector window never clears `matchFlag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Digit-period clock |
| rstN | input | 1 | Active-low synchronous reset |
| searchActive | input | 1 | High during an instruction or operand search phase |
| phaseSel | input | 1 | Address source: 0 selects the counter stream, 1 the instruction stream |
| digitCtr | input | 1 | Serial address digit from the program counter |
| digitInstr | input | 1 | Serial address digit from the instruction register |
| announce | input | 1 | Serial announcement of the next word's sector number |
| winSector | input | 1 | Marks the six sector-number digit periods |
| winTrack | input | 1 | Marks the six track-number digit periods |
| wordEnd | input | 1 | Marks the last digit period of a word |
| matchFlag | output | 1 | Sector agreement flag |
| seekDone | output | 1 | Target sector is next; the search phase may end |
| trackBits | output | 6 | Latched track number, bit 0 least significant |

## Verification
The bench builds the block with its default six-bit sector and six-bit track fields. It drives a 32-digit word, with the sector window on digits 0 to 5 and the track window on digits 8 to 13. With six-bit fields, random sector and track values cover the whole 64-entry space, including all-zero and all-one codes. The announcement equals the target in about half of the words, so both the match and the mismatch outcome occur often. The unused source stream is filled with random digits to show that only the selected stream counts. Directed words place the preset and a mismatching compare in the same cycle, and run full words with the search phase off.

// File: rtl/drum_seek_pkg.sv
package drum_seek_pkg;
  // Strobes passed from the sequencing logic to the datapath
  typedef struct packed {
    logic kPreset;   // force the match flag to 1
    logic kCompare;  // compare the announcement with the address digit
    logic trkShift;  // advance the track latch by one stage
    logic srcInstr;  // take address digits from the instruction stream
  } seekStrobes_t;
endpackage

// File: rtl/drum_seek_ctrl.sv
module drum_seek_ctrl
  import drum_seek_pkg::*;
(
  input  logic         searchActive,
  input  logic         phaseSel,
  input  logic         winSector,
  input  logic         winTrack,
  input  logic         wordEnd,
  input  logic         matchFlag,
  output seekStrobes_t strb,
  output logic         seekDone
);
  always_comb begin
    strb.kPreset  = wordEnd;
    strb.kCompare = searchActive & winSector & ~wordEnd;
    strb.trkShift = searchActive & winTrack;
    strb.srcInstr = phaseSel;
  end

  // The flag is sampled in the word-end digit before that digit's preset lands
  assign seekDone = searchActive & wordEnd & matchFlag;
endmodule

// File: rtl/drum_seek_dp.sv
module drum_seek_dp
  import drum_seek_pkg::*;
#(
  parameter int TRK_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  seekStrobes_t     strb,
  input  logic             digitCtr,
  input  logic             digitInstr,
  input  logic             announce,
  output logic             matchFlag,
  output logic [TRK_W-1:0] trackBits
);
  localparam int LAST = TRK_W - 1;

  logic             addrDigit;
  logic             kReg;
  logic [TRK_W-1:0] stage;  // stage[0] takes the incoming digit

  assign addrDigit = strb.srcInstr ? digitInstr : digitCtr;

  always_ff @(posedge clk) begin
    if (!rstN)                                  kReg <= 1'b0;
    else if (strb.kPreset)                      kReg <= 1'b1;
    else if (strb.kCompare && (announce != addrDigit)) kReg <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              stage[0] <= 1'b0;
    else if (strb.trkShift) stage[0] <= addrDigit;
  end

  for (genvar s = 1; s < TRK_W; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rstN)              stage[s] <= 1'b0;
      else if (strb.trkShift) stage[s] <= stage[s-1];
    end
  end

  // The digit that went in first sits in the last stage: it is the LSB
  for (genvar b = 0; b < TRK_W; b++) begin : g_out
    assign trackBits[b] = stage[LAST-b];
  end

  assign matchFlag = kReg;
endmodule

// File: rtl/drum_seek_unit.sv
module drum_seek_unit
  import drum_seek_pkg::*;
#(
  parameter int TRK_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             searchActive,
  input  logic             phaseSel,
  input  logic             digitCtr,
  input  logic             digitInstr,
  input  logic             announce,
  input  logic             winSector,
  input  logic             winTrack,
  input  logic             wordEnd,
  output logic             matchFlag,
  output logic             seekDone,
  output logic [TRK_W-1:0] trackBits
);
  seekStrobes_t strb;

  drum_seek_ctrl u_ctrl (
    .searchActive(searchActive),
    .phaseSel    (phaseSel),
    .winSector   (winSector),
    .winTrack    (winTrack),
    .wordEnd     (wordEnd),
    .matchFlag   (matchFlag),
    .strb        (strb),
    .seekDone    (seekDone)
  );

  drum_seek_dp #(.TRK_W(TRK_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .digitCtr  (digitCtr),
    .digitInstr(digitInstr),
    .announce  (announce),
    .matchFlag (matchFlag),
    .trackBits (trackBits)
  );
endmodule

// File: rtl/drum_seek_checker.sv
module drum_seek_checker #(
  parameter int TRK_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             searchActive,
  input logic             phaseSel,
  input logic             digitCtr,
  input logic             digitInstr,
  input logic             announce,
  input logic             winSector,
  input logic             winTrack,
  input logic             wordEnd,
  input logic             matchFlag,
  input logic             seekDone,
  input logic [TRK_W-1:0] trackBits
);
  logic pick;
  assign pick = phaseSel ? digitInstr : digitCtr;

  p_preset_r2: assert property (@(posedge clk) disable iff (!rstN)
    wordEnd |=> matchFlag);

  p_rise_only_at_end_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!wordEnd && !matchFlag) |=> !matchFlag);

  p_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    (searchActive && winSector && !wordEnd && (announce != pick)) |=> !matchFlag);

  p_done_r4: assert property (@(posedge clk) disable iff (!rstN)
    seekDone |-> (wordEnd && matchFlag));

  p_shift_in_r6: assert property (@(posedge clk) disable iff (!rstN)
    (searchActive && winTrack) |=> (trackBits[TRK_W-1] == $past(pick)));

  p_shift_down_r6: assert property (@(posedge clk) disable iff (!rstN)
    (searchActive && winTrack) |=> (trackBits[TRK_W-2:0] == $past(trackBits[TRK_W-1:1])));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(searchActive && winTrack) |=> $stable(trackBits));

  p_idle_keep_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!searchActive && matchFlag) |=> matchFlag);
endmodule

bind drum_seek_unit drum_seek_checker #(.TRK_W(TRK_W)) u_chk (
  .clk(clk), .rstN(rstN), .searchActive(searchActive), .phaseSel(phaseSel),
  .digitCtr(digitCtr), .digitInstr(digitInstr), .announce(announce),
  .winSector(winSector), .winTrack(winTrack), .wordEnd(wordEnd),
  .matchFlag(matchFlag), .seekDone(seekDone), .trackBits(trackBits)
);

// File: tb/sim_drum_seek_unit.sv
`timescale 1ns/1ps
module sim_drum_seek_unit;
  localparam int TRK_W = 6;
  localparam int SEC_W = 6;
  localparam int WORD_BITS = 32;
  localparam int U_START = 0;
  localparam int Z_START = 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic searchActive = 0, phaseSel = 0, digitCtr = 0, digitInstr = 0;
  logic announce = 0, winSector = 0, winTrack = 0, wordEnd = 0;
  logic matchFlag, seekDone;
  logic [TRK_W-1:0] trackBits;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [TRK_W-1:0] expTrack = '0;

  always #10 clk = ~clk;

  drum_seek_unit #(.TRK_W(TRK_W)) u0 (
    .clk(clk), .rstN(rstN), .searchActive(searchActive), .phaseSel(phaseSel),
    .digitCtr(digitCtr), .digitInstr(digitInstr), .announce(announce),
    .winSector(winSector), .winTrack(winTrack), .wordEnd(wordEnd),
    .matchFlag(matchFlag), .seekDone(seekDone), .trackBits(trackBits)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic expMatch(logic srch, logic [SEC_W-1:0] sec, logic [SEC_W-1:0] ann);
    return srch ? (sec == ann) : 1'b1;
  endfunction

  // One full word; the flag must already be preset by the previous word end
  task automatic runWord(logic srch, logic sel, logic [SEC_W-1:0] sec,
                         logic [TRK_W-1:0] trk, logic [SEC_W-1:0] ann);
    for (int d = 0; d < WORD_BITS; d++) begin
      logic dig;
      @(negedge clk);
      winSector = (d >= U_START) && (d < U_START + SEC_W);
      winTrack  = (d >= Z_START) && (d < Z_START + TRK_W);
      wordEnd   = (d == WORD_BITS - 1);
      searchActive = srch;
      phaseSel  = sel;
      dig = winSector ? sec[d-U_START] : (winTrack ? trk[d-Z_START] : 1'($urandom));
      announce  = winSector ? ann[d-U_START] : 1'($urandom);
      if (sel) begin digitInstr = dig; digitCtr = 1'($urandom); end
      else     begin digitCtr = dig; digitInstr = 1'($urandom); end
      #1;
      if (d == 0) check("R2 preset seen at word start", matchFlag, 1);
      if (wordEnd) begin
        check(srch ? "R3/R5 flag at word end" : "R8 flag kept while idle",
              matchFlag, expMatch(srch, sec, ann));
        check("R4 seekDone", seekDone, srch & expMatch(srch, sec, ann));
        if (srch) expTrack = trk;
        check(srch ? "R6/R5 track latched" : "R7 track held", trackBits, expTrack);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd1957));
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset flag", matchFlag, 0);
    check("R1 reset track", trackBits, 0);
    @(negedge clk); rstN = 1'b1;
    // Priming digit: word end presets the flag
    wordEnd = 1; @(negedge clk); wordEnd = 0; #1;
    check("R2 preset after first word end", matchFlag, 1);

    // Directed corners
    runWord(1, 0, 6'h00, 6'h3F, 6'h00);
    runWord(1, 1, 6'h3F, 6'h01, 6'h3F);
    runWord(1, 0, 6'h2A, 6'h20, 6'h2B);   // LSB mismatch
    runWord(1, 1, 6'h15, 6'h00, 6'h35);   // MSB mismatch
    runWord(0, 0, 6'h12, 6'h2D, 6'h00);   // idle: no clear, no shift

    // Preset and mismatching compare in the same digit
    @(negedge clk);
    searchActive = 1; phaseSel = 0; winSector = 1; winTrack = 0;
    wordEnd = 1; digitCtr = 1; announce = 0;
    @(negedge clk);
    wordEnd = 0; winSector = 0; #1;
    check("R2 preset wins over mismatch", matchFlag, 1);

    // Random words
    for (int w = 0; w < 60; w++) begin
      logic [SEC_W-1:0] sec = SEC_W'($urandom);
      logic [SEC_W-1:0] ann = ($urandom % 2) ? sec : SEC_W'($urandom);
      runWord(($urandom % 8) != 0, 1'($urandom), sec, TRK_W'($urandom), ann);
    end
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule